// File: doc/BRIEF.md
# Memory-Card Slot Status and Interrupt Block

This block sits on a word-addressed 32-bit register bus next to a memory-card slot. It returns a fixed identification word and a fixed decode word. It also returns a status word that shows the card write-protect switch as a live level and a card-insertion event as a sticky flag. An insertion raises an interrupt line. The line stays high until software acknowledges the event by writing a one to the flag's bit position. A word reserved for flash programming control always reads as zero and ignores writes.

The sticky flag is held by a two-state machine. The state EMPTY means that no insertion is pending, and PENDING means that one is. The transition ARM moves EMPTY to PENDING in any cycle where the insert input is high at the clock edge. The transition ACK moves PENDING to EMPTY on a clearing write, but only if the insert input is low in that same cycle. In every other case the state is held. The interrupt line is the PENDING state itself.

Reads are combinational and have no side effects. A write takes effect at the next rising clock edge. The bus is word addressed, so `bus_addr` counts 32-bit words.

Top module: `slot_card_status`

## Requirements
- R1: A read of word 0 returns 0x41034003, and a read of word 3 returns 0x00000011.
- R2: A read of word 1 returns zero. A read of any word other than 0 to 3 returns zero. `bus_rdata` is zero whenever no read is in progress (`bus_sel` low or `bus_wr` high).
- R3: In a read of word 2, bit 0 equals `wp_in` in the same cycle, with no register on the path.
- R4: If `ins_in` is high at a rising edge, bit 3 of word 2 is 1 from the next cycle on. It stays 1 after `ins_in` falls, as long as it is not cleared.
- R5: A write to word 2 with write-data bit 3 equal to 1 clears bit 3 from the next cycle. A write to word 2 with write-data bit 3 equal to 0 leaves bit 3 unchanged. No write changes bit 0.
- R6: `slot_irq` always equals the bit 3 that a read of word 2 would return.
- R7: If `ins_in` is high in the same cycle as a clearing write to word 2, bit 3 is 1 after that edge (the set wins).
- R8: Writes to words 0, 1 and 3 change neither the values later read from those words nor bit 3 of word 2.
- R9: During and right after reset, bit 3 of word 2 is 0 and `slot_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| wp_in | input | 1 | Card write-protect switch level |
| ins_in | input | 1 | Card-insert event level |
| slot_irq | output | 1 | Insertion interrupt, high while an event is pending |

## Verification
The assertions assume that `wp_in`, `ins_in` and every bus input are stable around the rising edge. They also assume that a cycle carries at most one access, with `bus_addr` meaningful only while `bus_sel` is high. The bench meets these conditions by changing every input 1 ns after a rising edge and sampling outputs on the falling edge. It drives directed sequences first: insert pulses, clears with and without bit 3, a clear in the same cycle as an insert, and writes to the fixed words. After that it runs random cycles that mix the two slot inputs with reads and writes to decoded and undecoded words.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY   = 1'b0,
        ST_PENDING = 1'b1
    } ins_state_e;

    localparam int          DATA_W      = 32;
    localparam int          NREG        = 4;
    localparam int          OFS_ID      = 0;
    localparam int          OFS_FLASH   = 1;
    localparam int          OFS_STAT    = 2;
    localparam int          OFS_DECODE  = 3;
    localparam int          WP_BIT      = 0;
    localparam int          INS_BIT     = 3;
    localparam logic [31:0] SLOT_ID_WORD = 32'h4103_4003;
    localparam logic [31:0] DECODE_WORD  = 32'h0000_0011;

endpackage

// File: rtl/slot_reg_decode.sv
module slot_reg_decode
    import slot_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wbit_ins,
    output logic [NREG-1:0]   rd_hit,
    output logic              clr_stb
);

    logic rd_cycle;
    logic wr_cycle;

    assign rd_cycle = bus_sel && !bus_wr;
    assign wr_cycle = bus_sel &&  bus_wr;

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign rd_hit[g] = rd_cycle && (bus_addr == ADDR_W'(g));
    end

    assign clr_stb = wr_cycle && (bus_addr == ADDR_W'(OFS_STAT)) && wbit_ins;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit)); // R2

    AST_NO_HIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (rd_hit == '0)); // R2

    AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |-> (bus_sel && bus_wr)); // R5

endmodule

// File: rtl/slot_insert_fsm.sv
module slot_insert_fsm
    import slot_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_lvl,
    input  logic clr_stb,
    output logic pend
);

    ins_state_e state_q;
    ins_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (ins_lvl) begin
                    state_d = ST_PENDING;            // ARM
                end
            end
            ST_PENDING: begin
                if (clr_stb && !ins_lvl) begin
                    state_d = ST_EMPTY;              // ACK
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        pend = (state_q == ST_PENDING);
    end

    AST_ARM_ON_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_lvl |=> pend); // R4

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_stb) |=> pend); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !ins_lvl) |=> !pend); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && ins_lvl) |=> pend); // R7

    AST_NO_SPURIOUS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !ins_lvl) |=> !pend); // R4

endmodule

// File: rtl/slot_rd_mux.sv
module slot_rd_mux
    import slot_ctl_pkg::*;
(
    input  logic [NREG-1:0]   rd_hit,
    input  logic              wp_lvl,
    input  logic              pend,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_hit[OFS_ID]) begin
            rdata = SLOT_ID_WORD;
        end
        if (rd_hit[OFS_FLASH]) begin
            rdata = '0;
        end
        if (rd_hit[OFS_STAT]) begin
            rdata[WP_BIT]  = wp_lvl;
            rdata[INS_BIT] = pend;
        end
        if (rd_hit[OFS_DECODE]) begin
            rdata = DECODE_WORD;
        end
    end

endmodule

// File: rtl/slot_card_status.sv
module slot_card_status
    import slot_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wp_in,
    input  logic              ins_in,
    output logic              slot_irq
);

    logic [NREG-1:0] rd_hit;
    logic            clr_stb;
    logic            pend;
    logic            unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:INS_BIT+1], bus_wdata[INS_BIT-1:0]};

    slot_reg_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wbit_ins (bus_wdata[INS_BIT]),
        .rd_hit   (rd_hit),
        .clr_stb  (clr_stb)
    );

    slot_insert_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_lvl (ins_in),
        .clr_stb (clr_stb),
        .pend    (pend)
    );

    slot_rd_mux u_mux (
        .rd_hit (rd_hit),
        .wp_lvl (wp_in),
        .pend   (pend),
        .rdata  (bus_rdata)
    );

    assign slot_irq = pend;

    AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_STAT))
            |-> (bus_rdata[INS_BIT] == slot_irq)); // R6

    AST_WP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_STAT))
            |-> (bus_rdata[WP_BIT] == wp_in)); // R3

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_ID))
            |-> (bus_rdata == 32'h4103_4003)); // R1

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr) |-> (bus_rdata == '0)); // R2

    AST_FIXED_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != ADDR_W'(OFS_STAT) && slot_irq)
            |=> slot_irq); // R8

endmodule

// File: tb/tb_slot_card_status.sv
`timescale 1ns/1ps
module tb_slot_card_status;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          wp_in = 1'b0;
    logic          ins_in = 1'b0;
    logic          slot_irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R9";
    int    mdl_pend = 0;

    always #2 clk = ~clk;

    slot_card_status #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wp_in     (wp_in),
        .ins_in    (ins_in),
        .slot_irq  (slot_irq)
    );

    // reference model: pending flag updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl_pend <= 0;
        else if (ins_in) mdl_pend <= 1;
        else if (bus_sel && bus_wr && int'(bus_addr) == 2 && bus_wdata[3]) mdl_pend <= 0;
    end

    function automatic logic [31:0] exp_rdata();
        int a = int'(bus_addr);
        if (!bus_sel || bus_wr) return 32'd0;
        case (a)
            0: return 32'h4103_4003;
            3: return 32'h0000_0011;
            2: return {28'd0, (mdl_pend != 0), 2'b00, wp_in};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (addr %0d sel %0b wr %0b)",
                     tag, act, exp, bus_addr, bus_sel, bus_wr);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check({cur_tag, " R6 irq"}, {31'd0, slot_irq}, {31'd0, (mdl_pend != 0)});
            if (rst_n) check(cur_tag, bus_rdata, exp_rdata());
        end
    end

    task automatic drive(input bit s, input bit w, input int a, input logic [31:0] d,
                         input bit wp, input bit ins);
        @(posedge clk);
        #1;
        bus_sel = s; bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
        wp_in = wp; ins_in = ins;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset, with insert high during reset
        cur_tag = "R9";
        ins_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 ins_in = 1'b0; bus_sel = 1'b1; bus_addr = AW'(2);
        rst_n = 1'b1;
        drive(1, 0, 2, 0, 0, 0);

        cur_tag = "R1";
        drive(1, 0, 0, 0, 0, 0);
        drive(1, 0, 3, 0, 0, 0);

        cur_tag = "R2";
        drive(1, 0, 1, 0, 0, 0);
        drive(1, 0, 5, 0, 0, 0);
        drive(1, 0, 40, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 1, 3, 0, 1, 0);

        cur_tag = "R3";
        for (int i = 0; i < 6; i++) drive(1, 0, 2, 0, i[0], 0);

        cur_tag = "R4";
        drive(1, 0, 2, 0, 0, 1);
        for (int i = 0; i < 4; i++) drive(1, 0, 2, 0, 0, 0);

        cur_tag = "R5";
        drive(1, 1, 2, 32'hFFFF_FFF7, 0, 0);
        drive(1, 0, 2, 0, 1, 0);
        drive(1, 1, 2, 32'h0000_0008, 1, 0);
        drive(1, 0, 2, 0, 1, 0);
        drive(1, 0, 2, 0, 0, 0);

        cur_tag = "R7";
        drive(1, 1, 2, 32'h8, 0, 1);
        drive(1, 0, 2, 0, 0, 0);
        drive(1, 0, 2, 0, 0, 0);

        cur_tag = "R8";
        drive(1, 1, 0, 32'hFFFF_FFFF, 0, 0);
        drive(1, 1, 1, 32'hFFFF_FFFF, 0, 0);
        drive(1, 1, 3, 32'hFFFF_FFFF, 0, 0);
        drive(1, 1, 9, 32'hFFFF_FFFF, 0, 0);
        drive(1, 0, 0, 0, 0, 0);
        drive(1, 0, 1, 0, 0, 0);
        drive(1, 0, 3, 0, 0, 0);
        drive(1, 0, 2, 0, 0, 0);
        drive(1, 1, 2, 32'h8, 0, 0);
        drive(1, 0, 2, 0, 0, 0);

        cur_tag = "R4 R5 R7 random";
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            int a = (r < 60) ? int'($urandom % 4) : int'($urandom % 64);
            logic [31:0] d = $urandom;
            drive($urandom % 4 != 0, $urandom % 3 == 0, a, d,
                  $urandom % 2 == 1, $urandom % 9 == 0);
        end

        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule